// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer that a processor must keep alive by writing a two-byte key to a service register. Once enabled, the counter runs at the system clock. If it reaches the end of its selected period before it has been serviced, the block drives an active-low reset output low for a fixed number of clocks. After that pulse the count starts again from zero.

Software sets the block up through a byte-wide register write port that has an address, data and a write strobe. A control register holds three settings: an enable bit, a prescaler bit and a two-bit range field. Together, the prescaler bit and the range field pick a power-of-two timeout. A single stray write cannot service the watchdog. The counter is cleared only when 0x55 is written and is directly followed, in the service register, by 0xAA.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, `wdog_rst_no` is high and the watchdog is disabled. The control register reads as zero, so it stays disabled until software enables it.
- R2: The counter holds at zero and no reset pulse starts while the enable bit is 0. The enable bit is bit 0 of the control register at address `CTRL_ADDR`.
- R3: With the prescaler bit clear, the range field selects an overflow period of 2^(BASE_EXP + STEP*range) clocks. The prescaler bit is bit 1 and the range field is bits 3:2. The first low cycle of `wdog_rst_no` comes at the period-th rising edge after the edge that wrote the enable.
- R4: Setting the prescaler bit multiplies the selected period by 2^PRE_EXP.
- R5: A write of 0xAA to the service register at `SVC_ADDR` clears the count when the previous service-register write was 0x55. A full period then follows before the next overflow.
- R6: A write of 0xAA does not service the watchdog when the previous service-register write was not 0x55. Any service-register write other than 0x55 disarms the key.
- R7: Consecutive writes of 0x55 leave the key armed. A write of 0xAA uses up the arming, so a second 0xAA straight after it does not service the watchdog.
- R8: An overflow drives `wdog_rst_no` low for exactly RST_LEN clocks. The count is held at zero during the pulse and resumes from zero afterwards, so the next overflow comes one full period after the pulse ends.
- R9: When a valid 0xAA write lands on the same edge as an overflow, the service wins and no reset pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 8 | Register write data |
| wdog_rst_no | output | 1 | Active-low reset pulse on overflow |

## Verification
Two functions can fall on the same clock edge: completing the service key and reaching the terminal count. The bench provokes this by timing the 0xAA write to land on exactly the edge where the counter would overflow. The result is judged correct if `wdog_rst_no` stays high and the next overflow comes one full period after that edge. A second collision is disabling the watchdog partway through a count, followed by re-enabling it. That case is judged correct if the re-enabled run again takes the complete period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  // control register layout, bits [3:0]
  typedef struct packed {
    logic [1:0] sel;  // [3:2] range
    logic       pre;  // [1]   prescaler
    logic       en;   // [0]   enable
  } wdog_ctrl_t;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_st_e;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned         ADDR_W    = 4,
  parameter logic [ADDR_W-1:0]   CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0]   SVC_ADDR  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [3:0]        ctrl_data_i,
  output wdog_ctrl_t        ctrl_o,
  output logic              svc_wr_o
);

  wdog_ctrl_t ctrl_q;
  logic       ctrl_wr;

  assign ctrl_wr  = wr_en_i && (wr_addr_i == CTRL_ADDR);
  assign svc_wr_o = wr_en_i && (wr_addr_i == SVC_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wdog_ctrl_t'(ctrl_data_i);
  end

  assign ctrl_o = ctrl_q;

  // R1
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(ctrl_q));

endmodule

// File: rtl/wdog_key.sv
module wdog_key
  import wdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       svc_wr_i,
  input  logic [7:0] data_i,
  output logic       kick_o
);

  key_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (svc_wr_i) st_d = (data_i == KEY_ARM) ? KEY_ARMED : KEY_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= KEY_IDLE;
    else         st_q <= st_d;
  end

  // same-edge service strobe
  assign kick_o = svc_wr_i && (data_i == KEY_FIRE) && (st_q == KEY_ARMED);

  // R7
  arm_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_wr_i && data_i == KEY_ARM) |=> (st_q == KEY_ARMED));

  // R6
  disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_wr_i && data_i != KEY_ARM) |=> (st_q == KEY_IDLE));

  // R6
  quiet_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !svc_wr_i |=> $stable(st_q));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_EXP = 9,
  parameter int unsigned STEP     = 2,
  parameter int unsigned PRE_EXP  = 9,
  parameter int unsigned RST_LEN  = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  wdog_ctrl_t ctrl_i,
  input  logic       kick_i,
  output logic       rst_no
);

  localparam int unsigned MAX_EXP = BASE_EXP + 3 * STEP + PRE_EXP;
  localparam int unsigned CNT_W   = MAX_EXP + 1;
  localparam int unsigned PLS_W   = $clog2(RST_LEN + 1);

  logic [CNT_W-1:0] rng_lim [4];
  logic [CNT_W-1:0] lim, lim_m1;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PLS_W-1:0] pls_q, pls_d;
  logic             rst_n_q;

  for (genvar g = 0; g < 4; g++) begin : g_rng
    assign rng_lim[g] = CNT_W'(1) << (BASE_EXP + STEP * g);
  end

  assign lim    = ctrl_i.pre ? (rng_lim[ctrl_i.sel] << PRE_EXP) : rng_lim[ctrl_i.sel];
  assign lim_m1 = lim - CNT_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    pls_d = pls_q;
    if (pls_q != '0) begin
      // pulse in flight: count parked, kicks ignored
      pls_d = pls_q - PLS_W'(1);
      cnt_d = '0;
    end else if (!ctrl_i.en || kick_i) begin
      cnt_d = '0;
    end else if (cnt_q == lim_m1) begin
      cnt_d = '0;
      pls_d = PLS_W'(RST_LEN);
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pls_q   <= '0;
      rst_n_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      pls_q   <= pls_d;
      rst_n_q <= (pls_d == '0);
    end
  end

  assign rst_no = rst_n_q;

  // R2
  hold_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.en |=> (cnt_q == '0));

  // R8
  pulse_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_n_q |-> (cnt_q == '0));

  // R8
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_n_q) |-> (pls_q == PLS_W'(RST_LEN)));

  // R5
  kick_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_i && rst_n_q) |=> (cnt_q == '0));

  // R9
  kick_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_i && rst_n_q) |=> rst_n_q);

  initial begin
    // R8
    rst_len_chk: assert (RST_LEN >= 1);
  end

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] SVC_ADDR  = 1,
  parameter int unsigned       BASE_EXP  = 9,
  parameter int unsigned       STEP      = 2,
  parameter int unsigned       PRE_EXP   = 9,
  parameter int unsigned       RST_LEN   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              wdog_rst_no
);

  wdog_ctrl_t ctrl;
  logic       svc_wr;
  logic       kick;

  wdog_regs #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .SVC_ADDR (SVC_ADDR)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .ctrl_data_i(wr_data_i[3:0]),
    .ctrl_o     (ctrl),
    .svc_wr_o   (svc_wr)
  );

  wdog_key u_key (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .svc_wr_i(svc_wr),
    .data_i  (wr_data_i),
    .kick_o  (kick)
  );

  wdog_timer #(
    .BASE_EXP(BASE_EXP),
    .STEP    (STEP),
    .PRE_EXP (PRE_EXP),
    .RST_LEN (RST_LEN)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ctrl_i(ctrl),
    .kick_i(kick),
    .rst_no(wdog_rst_no)
  );

  // R1
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.en && wdog_rst_no) |=> wdog_rst_no);

endmodule

// File: tb/tb_keyed_wdog.sv
module tb_keyed_wdog;

  localparam int RST_LEN = 5;
  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_SVC  = 4'h1;

  // ctrl byte {sel[3:2], pre[1], en[0]} and expected period (BASE 3, STEP 2, PRE 2)
  localparam logic [7:0] VEC_CTRL [8] = '{8'h01, 8'h05, 8'h09, 8'h0D,
                                          8'h03, 8'h07, 8'h0B, 8'h0F};
  localparam int         VEC_LIM  [8] = '{8, 32, 128, 512, 32, 128, 512, 2048};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wdog_rst_n;

  int checks = 0;
  int failures = 0;
  int n;

  always #2.5 clk = ~clk;

  keyed_wdog #(
    .ADDR_W(4), .CTRL_ADDR(A_CTRL), .SVC_ADDR(A_SVC),
    .BASE_EXP(3), .STEP(2), .PRE_EXP(2), .RST_LEN(RST_LEN)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wdog_rst_no(wdog_rst_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; occupies exactly one rising edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  // edges until reset output observed low
  task automatic measure(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (wdog_rst_n && cnt < 5000);
  endtask

  task automatic pulse_width(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!wdog_rst_n && cnt < 100);
  endtask

  task automatic quiesce();
    wr(A_CTRL, 8'h00);
    wr(A_SVC, 8'h00);
    for (int i = 0; i < 20 && !wdog_rst_n; i++) @(negedge clk);
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lo;
    idle(3);
    chk("R1 output high in reset", int'(wdog_rst_n), 1);
    rst_n = 1'b1;
    idle(2);
    chk("R1 output high after reset", int'(wdog_rst_n), 1);

    // R2: disabled for a long time, no pulse
    lo = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!wdog_rst_n) lo++;
    end
    chk("R2 no pulse while disabled", lo, 0);

    // R3 R4: table of ranges and prescaler, plus R8 pulse width
    for (int v = 0; v < 8; v++) begin
      wr(A_CTRL, VEC_CTRL[v]);
      measure(n);
      chk(v < 4 ? "R3 range period" : "R4 prescaled period", n, VEC_LIM[v]);
      pulse_width(n);
      chk("R8 pulse width", n, RST_LEN);
      quiesce();
    end

    // R8: count restarts from zero after pulse
    wr(A_CTRL, 8'h05);
    measure(n);
    pulse_width(n);
    measure(n);
    chk("R8 restart full period after pulse", n, 32);
    quiesce();

    // R5: repeated servicing keeps it alive past the period
    wr(A_CTRL, 8'h05);
    lo = 0;
    for (int k = 0; k < 5; k++) begin
      idle(8);
      if (!wdog_rst_n) lo++;
      wr(A_SVC, 8'h55);
      wr(A_SVC, 8'hAA);
    end
    chk("R5 serviced no pulse", lo, 0);
    measure(n);
    chk("R5 full period after service", n, 32);
    quiesce();

    // R6: 0xAA without arming
    wr(A_CTRL, 8'h01);
    wr(A_SVC, 8'hAA);
    measure(n);
    chk("R6 unarmed AA ignored", n, 7);
    quiesce();

    // R6: other value disarms
    wr(A_CTRL, 8'h01);
    wr(A_SVC, 8'h55);
    wr(A_SVC, 8'h12);
    wr(A_SVC, 8'hAA);
    measure(n);
    chk("R6 other value disarms", n, 5);
    quiesce();

    // R7: multiple 0x55 stay armed
    wr(A_CTRL, 8'h05);
    wr(A_SVC, 8'h55);
    wr(A_SVC, 8'h55);
    wr(A_SVC, 8'h55);
    wr(A_SVC, 8'hAA);
    measure(n);
    chk("R7 repeated 55 then AA services", n, 32);
    quiesce();

    // R7: second AA not a service
    wr(A_CTRL, 8'h01);
    wr(A_SVC, 8'h55);
    wr(A_SVC, 8'hAA);
    idle(3);
    wr(A_SVC, 8'hAA);
    measure(n);
    chk("R7 second AA ignored", n, 4);
    quiesce();

    // R9: service on the overflow edge wins
    wr(A_CTRL, 8'h01);
    idle(5);
    wr(A_SVC, 8'h55);
    idle(1);
    wr(A_SVC, 8'hAA);
    chk("R9 no pulse on collision", int'(wdog_rst_n), 1);
    measure(n);
    chk("R9 full period after collision", n, 8);
    quiesce();

    // R2: disable mid-count holds at zero
    wr(A_CTRL, 8'h01);
    idle(4);
    wr(A_CTRL, 8'h00);
    lo = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!wdog_rst_n) lo++;
    end
    chk("R2 no pulse after disable", lo, 0);
    wr(A_CTRL, 8'h01);
    measure(n);
    chk("R2 count restarted from zero", n, 8);
    quiesce();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule